// File: doc/BRIEF.md
# Receive FIFO Flow Threshold Controller

This block sits beside a 128-entry receive FIFO and turns its live fill count into flow-control decisions. It drives an active-low request-to-send output with hysteresis. It raises a receive trigger interrupt request. It issues single-cycle requests asking the transmitter to send a stop character or a resume character. The FIFO storage, the serial shifter and the register decode live elsewhere. This block sees only the count and a set of static configuration inputs.

There are two threshold sources. In coded mode, a 2-bit trigger code selects one level from a four-entry table. The request-to-send output goes off only at the next table level above the selected one. It comes back on only when the FIFO drains to the next table level below. In programmable mode, a high and a low byte threshold (each 1 to 128) set the off and on points directly. The caller must keep high above low; the block does not check this. The FIFO keeps accepting data after the request-to-send goes off, up to full. The off state therefore holds for any count up to 128.

Top module: `rxfc_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `rts_n`=0, `rx_trig_irq`=0, `send_stop`=0 and `send_resume`=0.
- R2: In coded mode (`ext_en`=0), the trigger level is 8, 16, 56 or 60 for `trig_code` 0, 1, 2 or 3. `rx_trig_irq` is 1 in the cycle after an edge where `fifo_cnt` is at or above the level, and 0 otherwise.
- R3: In coded mode, `rts_n` rises to 1 in the cycle after an edge where `fifo_cnt` is at or above the next level up: 16, 56, 60 or 128 for codes 0 to 3. It does not rise at any lower count.
- R4: In coded mode, once `rts_n` is 1, it falls to 0 in the cycle after an edge where `fifo_cnt` is at or below the next level down: 0, 8, 16 or 56 for codes 0 to 3.
- R5: In programmable mode (`ext_en`=1), `rts_n` rises after a count at or above `thr_hi`. It falls after a count at or below `thr_lo`.
- R6: `send_stop` is high for exactly the one cycle in which `rts_n` goes from 0 to 1. `send_resume` is high for exactly the one cycle in which `rts_n` goes from 1 to 0. Neither is high at any other time.
- R7: Counts strictly between the release point and the off point leave `rts_n` unchanged, in both modes. This includes counts above the off point while `rts_n` is already 1.
- R8: In programmable mode, `rx_trig_irq` is 1 in the cycle after an edge where `fifo_cnt` is at or above `thr_hi`, and 0 otherwise.
- R9: The programmable thresholds behave the same at the extreme values `thr_hi`=128 and `thr_lo`=1 as at mid-range values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_cnt | input | 8 | Live receive FIFO fill count, 0 to 128 |
| trig_code | input | 2 | Coded trigger table index |
| ext_en | input | 1 | 1 selects the programmable thresholds, 0 selects the coded table |
| thr_hi | input | 8 | Programmable off/stop threshold |
| thr_lo | input | 8 | Programmable on/resume threshold |
| rts_n | output | 1 | Request-to-send, 0 = asserted (send), 1 = off |
| rx_trig_irq | output | 1 | Receive trigger interrupt request |
| send_stop | output | 1 | One-cycle request to transmit a stop character |
| send_resume | output | 1 | One-cycle request to transmit a resume character |

## Verification
Directed ramps run the count from empty to full and back for each trigger code. These ramps separate the trigger level, the off point one table step higher, and the release point one table step lower. A buggy table index or a single-comparator scheme shows up as an edge at the wrong count. A programmable ramp with thresholds at 128 and 1 probes the range ends, and a mid-range pair exercises ordinary use. A constrained random walk then moves the count in small steps and switches the code, the mode and the thresholds now and then. This stresses hysteresis retention, mode switching while the output is off, and the rule that a stop or resume pulse appears only on a real transition.

// File: rtl/rxfc_pkg.sv
// Package: rxfc_pkg
// Shared types and the hysteresis next-state rule for the receive flow
// threshold controller. Assumes counts are unsigned and never exceed depth.
package rxfc_pkg;

    typedef enum logic {
        MODE_CODED = 1'b0,
        MODE_PROG  = 1'b1
    } rxfc_mode_e;

    // Next off-state: set at the upper point, cleared at the lower point.
    function automatic logic rxfc_next_off(input logic off_now,
                                           input logic at_upper,
                                           input logic at_lower);
        return off_now ? !at_lower : at_upper;
    endfunction

endpackage

// File: rtl/rxfc_thresh_sel.sv
// Module: rxfc_thresh_sel
// Picks the interrupt trigger level, the off point and the release point.
// In coded mode these come from a four-entry table and its neighbours.
// The neighbour above the top entry saturates at DEPTH.
// The neighbour below the bottom entry is zero.
// In programmable mode they come from the high/low inputs.
// Assumes hi > lo in programmable mode; this is not checked.
module rxfc_thresh_sel #(
    parameter int DEPTH    = 128,
    parameter int CNT_W    = $clog2(DEPTH + 1),
    parameter int LVL0     = 8,
    parameter int LVL1     = 16,
    parameter int LVL2     = 56,
    parameter int LVL3     = 60,
    parameter bit HAS_PROG = 1'b1
) (
    input  logic [1:0]       code_i,
    input  logic             ext_i,
    input  logic [CNT_W-1:0] hi_i,
    input  logic [CNT_W-1:0] lo_i,
    output logic [CNT_W-1:0] trig_o,
    output logic [CNT_W-1:0] upper_o,
    output logic [CNT_W-1:0] lower_o
);
    import rxfc_pkg::*;

    localparam int NLVL = 4;
    localparam logic [CNT_W-1:0] TOP  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] tbl [NLVL];
    logic [CNT_W-1:0] c_trig, c_up, c_dn;

    // Table of coded levels as constant nets.
    assign tbl[0] = CNT_W'(LVL0);
    assign tbl[1] = CNT_W'(LVL1);
    assign tbl[2] = CNT_W'(LVL2);
    assign tbl[3] = CNT_W'(LVL3);

    // Coded lookup: selected level plus its upper and lower neighbours.
    always_comb begin
        c_trig = tbl[code_i];
        c_up   = (code_i == 2'(NLVL - 1)) ? TOP  : tbl[code_i + 2'd1];
        c_dn   = (code_i == 2'd0)         ? ZERO : tbl[code_i - 2'd1];
    end

    generate
        if (HAS_PROG) begin : g_prog
            rxfc_mode_e mode;
            assign mode = rxfc_mode_e'(ext_i);
            // Source select between the coded table and the programmable pair.
            always_comb begin
                if (mode == MODE_PROG) begin
                    trig_o  = hi_i;
                    upper_o = hi_i;
                    lower_o = lo_i;
                end else begin
                    trig_o  = c_trig;
                    upper_o = c_up;
                    lower_o = c_dn;
                end
            end
        end else begin : g_coded
            logic unused_prog;
            assign unused_prog = ^{ext_i, hi_i, lo_i};
            assign trig_o  = c_trig;
            assign upper_o = c_up;
            assign lower_o = c_dn;
        end
    endgenerate

endmodule

// File: rtl/rxfc_hyst.sv
// Module: rxfc_hyst
// Holds the request-to-send off state with hysteresis.
// It emits one-cycle stop/resume pulses on each change of state.
// Assumes upper/lower are already resolved for the active mode.
module rxfc_hyst #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] upper_i,
    input  logic [CNT_W-1:0] lower_i,
    output logic             off_o,
    output logic             stop_o,
    output logic             resume_o
);
    import rxfc_pkg::*;

    logic off_q, stop_q, resume_q, off_d;

    // Next state from the two threshold comparisons.
    always_comb begin
        off_d = rxfc_next_off(off_q, cnt_i >= upper_i, cnt_i <= lower_i);
    end

    // Register state and the transition pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q    <= 1'b0;
            stop_q   <= 1'b0;
            resume_q <= 1'b0;
        end else begin
            off_q    <= off_d;
            stop_q   <= !off_q && off_d;
            resume_q <= off_q && !off_d;
        end
    end

    assign off_o    = off_q;
    assign stop_o   = stop_q;
    assign resume_o = resume_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!off_q && !stop_q && !resume_q));
    // R6
    stop_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(off_q) |-> stop_q);
    // R6
    stop_needs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_q |-> off_q);
    // R6
    resume_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume_q |-> !off_q);
    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_q && resume_q));
    // R7
    hold_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!off_q && cnt_i < upper_i) |=> !off_q);
    // R7
    hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off_q && cnt_i > lower_i) |=> off_q);

endmodule

// File: rtl/rxfc_irq.sv
// Module: rxfc_irq
// Registers the receive trigger interrupt request from a level compare.
// Assumes the trigger level is already resolved for the active mode.
module rxfc_irq #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] trig_i,
    output logic             irq_o
);
    logic irq_q;

    // Level-sensitive request, registered.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (cnt_i >= trig_i);
    end

    assign irq_o = irq_q;

    // R2
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i >= trig_i) |=> irq_q);
    // R2
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i < trig_i) |=> !irq_q);

endmodule

// File: rtl/rxfc_ctrl.sv
// Module: rxfc_ctrl (top)
// Receive FIFO flow threshold controller.
// Threshold selection feeds two registered stages: hysteresis and interrupt.
// Assumes fifo_cnt <= DEPTH. In programmable mode it assumes thr_hi > thr_lo.
module rxfc_ctrl #(
    parameter int DEPTH = 128,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int LVL0  = 8,
    parameter int LVL1  = 16,
    parameter int LVL2  = 56,
    parameter int LVL3  = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic [1:0]       trig_code,
    input  logic             ext_en,
    input  logic [CNT_W-1:0] thr_hi,
    input  logic [CNT_W-1:0] thr_lo,
    output logic             rts_n,
    output logic             rx_trig_irq,
    output logic             send_stop,
    output logic             send_resume
);
    logic [CNT_W-1:0] trig, upper, lower;

    rxfc_thresh_sel #(
        .DEPTH(DEPTH), .CNT_W(CNT_W),
        .LVL0(LVL0), .LVL1(LVL1), .LVL2(LVL2), .LVL3(LVL3),
        .HAS_PROG(1'b1)
    ) u_sel (
        .code_i (trig_code),
        .ext_i  (ext_en),
        .hi_i   (thr_hi),
        .lo_i   (thr_lo),
        .trig_o (trig),
        .upper_o(upper),
        .lower_o(lower)
    );

    rxfc_hyst #(.CNT_W(CNT_W)) u_hyst (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (fifo_cnt),
        .upper_i (upper),
        .lower_i (lower),
        .off_o   (rts_n),
        .stop_o  (send_stop),
        .resume_o(send_resume)
    );

    rxfc_irq #(.CNT_W(CNT_W)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_i (fifo_cnt),
        .trig_i(trig),
        .irq_o (rx_trig_irq)
    );

endmodule

// File: tb/rxfc_ctrl_test.sv
// Bench: directed ramps plus a seeded random walk, checked against a model.
module rxfc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] fifo_cnt;
    logic [1:0] trig_code;
    logic       ext_en;
    logic [7:0] thr_hi, thr_lo;
    logic       rts_n, rx_trig_irq, send_stop, send_resume;

    int n_tests = 0;
    int n_fail  = 0;
    logic m_off = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    rxfc_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fifo_cnt(fifo_cnt), .trig_code(trig_code),
        .ext_en(ext_en), .thr_hi(thr_hi), .thr_lo(thr_lo), .rts_n(rts_n),
        .rx_trig_irq(rx_trig_irq), .send_stop(send_stop), .send_resume(send_resume)
    );

    function automatic int lvl(input int c);
        case (c)
            0: return 8;
            1: return 16;
            2: return 56;
            default: return 60;
        endcase
    endfunction
    function automatic int up_pt(input int c);
        return (c == 3) ? 128 : lvl(c + 1);
    endfunction
    function automatic int dn_pt(input int c);
        return (c == 0) ? 0 : lvl(c - 1);
    endfunction

    task automatic check(input string req, input logic act, input logic exp,
                         input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s cnt=%0d actual=%0b expected=%0b",
                     req, what, fifo_cnt, act, exp);
        end
    endtask

    // Drive one count, clock once, compare with the model.
    task automatic step(input int c, input string tag);
        int trig, up, dn;
        logic nxt;
        string rq_rts, rq_irq;
        fifo_cnt = 8'(c);
        @(posedge clk); #1;
        if (ext_en) begin
            trig = thr_hi; up = thr_hi; dn = thr_lo;
        end else begin
            trig = lvl(trig_code); up = up_pt(trig_code); dn = dn_pt(trig_code);
        end
        nxt = m_off ? !(c <= dn) : (c >= up);
        if (ext_en)            rq_rts = "R5";
        else if (nxt && !m_off) rq_rts = "R3";
        else if (!nxt && m_off) rq_rts = "R4";
        else                   rq_rts = "R7";
        rq_irq = ext_en ? "R8" : "R2";
        check({rq_rts, " ", tag}, rts_n, nxt, "rts_n");
        check({rq_irq, " ", tag}, rx_trig_irq, c >= trig, "rx_trig_irq");
        check({"R6 ", tag}, send_stop, nxt && !m_off, "send_stop");
        check({"R6 ", tag}, send_resume, !nxt && m_off, "send_resume");
        m_off = nxt;
    endtask

    task automatic ramp(input string tag);
        for (int i = 0; i <= 128; i++) step(i, tag);
        for (int i = 128; i >= 0; i--) step(i, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; fifo_cnt = 8'd100; trig_code = 2'd0; ext_en = 1'b0;
        thr_hi = 8'd10; thr_lo = 8'd5;
        repeat (3) @(posedge clk);
        #1;
        check("R1", rts_n, 1'b0, "rts_n");
        check("R1", rx_trig_irq, 1'b0, "rx_trig_irq");
        check("R1", send_stop, 1'b0, "send_stop");
        check("R1", send_resume, 1'b0, "send_resume");
        fifo_cnt = 8'd0; rst_n = 1'b1; m_off = 1'b0;

        // Coded ramps for each code.
        for (int k = 0; k < 4; k++) begin
            trig_code = 2'(k);
            ramp("coded");
        end

        // Programmable extremes, then a mid-range pair.
        ext_en = 1'b1; thr_hi = 8'd128; thr_lo = 8'd1;
        ramp("R9");
        thr_hi = 8'd10; thr_lo = 8'd5;
        ramp("prog");

        // Random walk with occasional configuration changes.
        begin
            int c = 0;
            for (int n = 0; n < 4000; n++) begin
                if ($urandom_range(0, 99) == 0) begin
                    int h = $urandom_range(2, 128);
                    ext_en    = 1'($urandom_range(0, 1));
                    trig_code = 2'($urandom_range(0, 3));
                    thr_hi    = 8'(h);
                    thr_lo    = 8'($urandom_range(1, h - 1));
                end
                c = c + $urandom_range(0, 12) - 6;
                if (c < 0) c = 0;
                if (c > 128) c = 128;
                step(c, "rand");
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule